// File: doc/BRIEF.md
# Effective Address Sequencer

This block is the operand-fetch stage of a small 8-bit processor core. When the decoder pulses `start`, it passes the block a three-bit addressing-mode code, the address of the first operand byte, and the current values of the two index registers. The sequencer then reads the operand bytes that follow the opcode. If the mode needs a pointer, it reads the pointer from page zero. It combines the bytes with an index value where the mode asks for one, and finally reads the operand byte itself. It finishes with a one-cycle `done` pulse that presents the operand, its 16-bit effective address and the advanced program counter.

All reads go through one byte-wide synchronous port. The block raises `mem_rd` with `mem_addr` for one cycle and takes `mem_rdata` on the next cycle. Each state makes at most one request, so the time to `done` depends only on the mode. The arithmetic unit that consumes the operand and the fetch of the next opcode belong to neighbouring blocks.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, and again after any reset asserted part-way through a sequence, `busy`, `done` and `mem_rd` are all low.
- R2: Mode codes are 0 immediate, 1 page-zero, 2 page-zero+X, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 pre-indexed pointer (X), 7 post-indexed pointer (Y). The number of memory reads is 1, 2, 2, 3, 3, 3, 4 and 4 respectively. Each read holds `mem_rd` high for exactly one cycle and is followed by one cycle with `mem_rd` low. The reads are issued in the order the mode's rule gives. `done` is high in the cycle after the 2·n-th rising edge that follows the edge sampling `start`, where n is the read count.
- R3: In immediate mode, the single read is at the start address. `operand` is that byte, `eff_addr` is the start address, and no further read is made.
- R4: Page-zero mode addresses {0x00, b0}, where b0 is the byte at the start address. Page-zero+X addresses {0x00, (b0 + X) mod 256}. For example, b0 = 0xF1 with X = 5 gives 0x00F6, and b0 = 0xF0 with X = 0x20 gives 0x0010.
- R5: The absolute modes read the low byte at the start address and then the high byte at start+1 (mod 65536). The +X and +Y forms add the index to the full 16-bit value modulo 65536, so 0x36F1 + 8 gives 0x36F9 and 0xFFF9 + 0x10 gives 0x0009.
- R6: Pre-indexed pointer mode forms p = (b0 + X) mod 256. It reads the low target byte at 0x00p and the high target byte at 0x00((p+1) mod 256), and the effective address is {high, low}.
- R7: Post-indexed pointer mode reads the low pointer byte at 0x00b0 and the high pointer byte at 0x00((b0+1) mod 256). The effective address is ({high, low} + Y) mod 65536.
- R8: `done` lasts one cycle. While it is high, every mode except immediate presents on `operand` the byte read from `eff_addr`.
- R9: A `start` that arrives while `busy` is high, including the `done` cycle, has no effect: the running sequence finishes with its own results and no new sequence follows.
- R10: While `done` is high, `pc_out` equals the start address plus the number of operand bytes taken from the instruction stream, modulo 65536. That count is two for the absolute modes and one for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mode | input | 3 | Addressing-mode code, see R2 |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index value, captured at start |
| y_in | input | 8 | Y index value, captured at start |
| mem_rd | output | 1 | Read request strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 8 | Operand value, valid with done |
| eff_addr | output | 16 | Effective address, valid with done |
| pc_out | output | 16 | Advanced program counter, valid with done |

## Verification
The bench builds the block with its default 8-bit data and 16-bit address widths. At these widths every mode can be driven against a memory whose contents are a closed-form function of the address, with a few patched locations. The sweep runs all eight modes across start addresses that include 0xFFFF, and across index values 0x00, 0x22, 0x80 and 0xFF. This reaches 16-bit carry into the next page, program-counter wrap at the top of memory, and page-zero pointer wrap at 0xFF. Patched memory locations reproduce the worked address examples and force pointer reads across the 0xFF/0x00 boundary.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_DW = 8;
    localparam int EA_AW = 2 * EA_DW;
    localparam int EA_MW = 3;

    typedef enum logic [EA_MW-1:0] {
        AM_IMM = 3'd0,
        AM_ZPG = 3'd1,
        AM_ZPX = 3'd2,
        AM_ABS = 3'd3,
        AM_ABX = 3'd4,
        AM_ABY = 3'd5,
        AM_INX = 3'd6,
        AM_INY = 3'd7
    } am_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OP0_REQ,
        ST_OP0_CAP,
        ST_OP1_REQ,
        ST_OP1_CAP,
        ST_PL_REQ,
        ST_PL_CAP,
        ST_PH_REQ,
        ST_PH_CAP,
        ST_DAT_REQ,
        ST_DAT_CAP,
        ST_DONE
    } st_e;

    // values frozen when a sequence is accepted
    typedef struct packed {
        am_e              mode;
        logic [EA_DW-1:0] xi;
        logic [EA_DW-1:0] yi;
        logic [EA_AW-1:0] pc0;
    } ea_ctx_t;

    // bytes gathered from memory during a sequence
    typedef struct packed {
        logic [EA_DW-1:0] op0;
        logic [EA_DW-1:0] op1;
        logic [EA_DW-1:0] plo;
        logic [EA_DW-1:0] phi;
        logic [EA_DW-1:0] dat;
    } ea_bytes_t;

    function automatic logic mode_abs(am_e m);
        return (m == AM_ABS) || (m == AM_ABX) || (m == AM_ABY);
    endfunction

    function automatic logic mode_ptr(am_e m);
        return (m == AM_INX) || (m == AM_INY);
    endfunction

    function automatic logic mode_pre_x(am_e m);
        return (m == AM_ZPX) || (m == AM_INX);
    endfunction

    // index added after the base address has been formed
    function automatic logic [EA_DW-1:0] post_index(am_e m, logic [EA_DW-1:0] x,
                                                    logic [EA_DW-1:0] y);
        logic [EA_DW-1:0] r;
        case (m)
            AM_ABX:          r = x;
            AM_ABY, AM_INY:  r = y;
            default:         r = '0;
        endcase
        return r;
    endfunction

    function automatic logic is_req(st_e s);
        return (s == ST_OP0_REQ) || (s == ST_OP1_REQ) || (s == ST_PL_REQ) ||
               (s == ST_PH_REQ) || (s == ST_DAT_REQ);
    endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  am_e  mode_q,
    output st_e  state,
    output logic accept
);

    st_e nxt;

    always_comb accept = start && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start) nxt = ST_OP0_REQ;
            ST_OP0_REQ: nxt = ST_OP0_CAP;
            ST_OP0_CAP: begin
                if (mode_q == AM_IMM)      nxt = ST_DONE;
                else if (mode_abs(mode_q)) nxt = ST_OP1_REQ;
                else if (mode_ptr(mode_q)) nxt = ST_PL_REQ;
                else                       nxt = ST_DAT_REQ;
            end
            ST_OP1_REQ: nxt = ST_OP1_CAP;
            ST_OP1_CAP: nxt = ST_DAT_REQ;
            ST_PL_REQ:  nxt = ST_PL_CAP;
            ST_PL_CAP:  nxt = ST_PH_REQ;
            ST_PH_REQ:  nxt = ST_PH_CAP;
            ST_PH_CAP:  nxt = ST_DAT_REQ;
            ST_DAT_REQ: nxt = ST_DAT_CAP;
            ST_DAT_CAP: nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && state != ST_IDLE) |=> (state != ST_OP0_REQ));

    // R3
    imm_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DAT_REQ) |-> (mode_q != AM_IMM));

endmodule

// File: rtl/ea_capture.sv
module ea_capture
    import ea_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  st_e              state,
    input  logic [EA_MW-1:0] mode_in,
    input  logic [EA_AW-1:0] pc_in,
    input  logic [EA_DW-1:0] x_in,
    input  logic [EA_DW-1:0] y_in,
    input  logic [EA_DW-1:0] mem_rdata,
    output ea_ctx_t          ctx,
    output ea_bytes_t        bytes_q,
    output logic [EA_AW-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '0;
            bytes_q <= '0;
            pc_q    <= '0;
        end else begin
            if (accept) begin
                ctx.mode <= am_e'(mode_in);
                ctx.xi   <= x_in;
                ctx.yi   <= y_in;
                ctx.pc0  <= pc_in;
                pc_q     <= pc_in;
            end
            case (state)
                ST_OP0_CAP: begin
                    bytes_q.op0 <= mem_rdata;
                    pc_q        <= pc_q + EA_AW'(1);
                end
                ST_OP1_CAP: begin
                    bytes_q.op1 <= mem_rdata;
                    pc_q        <= pc_q + EA_AW'(1);
                end
                ST_PL_CAP:  bytes_q.plo <= mem_rdata;
                ST_PH_CAP:  bytes_q.phi <= mem_rdata;
                ST_DAT_CAP: bytes_q.dat <= mem_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ea_addr.sv
module ea_addr
    import ea_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  st_e              state,
    input  ea_ctx_t          ctx,
    input  logic [EA_AW-1:0] pc_q,
    input  logic [EA_DW-1:0] op0,
    input  logic [EA_DW-1:0] op1,
    input  logic [EA_DW-1:0] plo,
    input  logic [EA_DW-1:0] phi,
    output logic             mem_rd,
    output logic [EA_AW-1:0] mem_addr,
    output logic [EA_AW-1:0] eff_addr
);

    localparam int HI_W = EA_AW - EA_DW;

    logic [EA_DW-1:0] zp_idx;
    logic [EA_DW-1:0] zp_next;
    logic [EA_AW-1:0] base;

    always_comb begin
        // page-zero sums stay inside EA_DW bits
        zp_idx  = op0 + (mode_pre_x(ctx.mode) ? ctx.xi : '0);
        zp_next = zp_idx + EA_DW'(1);

        if (ctx.mode == AM_IMM)      base = ctx.pc0;
        else if (mode_abs(ctx.mode)) base = {op1, op0};
        else if (mode_ptr(ctx.mode)) base = {phi, plo};
        else                         base = {{HI_W{1'b0}}, zp_idx};

        eff_addr = base + {{HI_W{1'b0}}, post_index(ctx.mode, ctx.xi, ctx.yi)};
    end

    always_comb begin
        mem_rd = is_req(state);
        case (state)
            ST_OP0_REQ, ST_OP1_REQ: mem_addr = pc_q;
            ST_PL_REQ:              mem_addr = {{HI_W{1'b0}}, zp_idx};
            ST_PH_REQ:              mem_addr = {{HI_W{1'b0}}, zp_next};
            ST_DAT_REQ:             mem_addr = eff_addr;
            default:                mem_addr = '0;
        endcase
    end

    // R6
    ptr_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PH_REQ) |->
        (mem_addr[EA_AW-1:EA_DW] == '0 &&
         mem_addr[EA_DW-1:0] == $past(mem_addr[EA_DW-1:0], 2) + EA_DW'(1)));

    // R5
    abs_hi_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OP1_REQ) |-> (mem_addr == $past(mem_addr, 2) + EA_AW'(1)));

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [EA_MW-1:0] mode,
    input  logic [EA_AW-1:0] pc_in,
    input  logic [EA_DW-1:0] x_in,
    input  logic [EA_DW-1:0] y_in,
    output logic             mem_rd,
    output logic [EA_AW-1:0] mem_addr,
    input  logic [EA_DW-1:0] mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [EA_DW-1:0] operand,
    output logic [EA_AW-1:0] eff_addr,
    output logic [EA_AW-1:0] pc_out
);

    st_e              state;
    logic             accept;
    ea_ctx_t          ctx;
    ea_bytes_t        bytes_q;
    logic [EA_AW-1:0] pc_q;

    ea_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .mode_q (ctx.mode),
        .state  (state),
        .accept (accept)
    );

    ea_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .state     (state),
        .mode_in   (mode),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .mem_rdata (mem_rdata),
        .ctx       (ctx),
        .bytes_q   (bytes_q),
        .pc_q      (pc_q)
    );

    ea_addr u_addr (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .ctx      (ctx),
        .pc_q     (pc_q),
        .op0      (bytes_q.op0),
        .op1      (bytes_q.op1),
        .plo      (bytes_q.plo),
        .phi      (bytes_q.phi),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .eff_addr (eff_addr)
    );

    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        operand = (ctx.mode == AM_IMM) ? bytes_q.op0 : bytes_q.dat;
        pc_out  = pc_q;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !done));

endmodule

// File: tb/ea_sequencer_test.sv
module ea_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  x_i = '0;
    logic [7:0]  y_i = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;
    logic [7:0]  operand;
    logic [15:0] eff_addr, pc_out;

    always #10 clk = ~clk;

    ea_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode_i), .pc_in(pc_i),
        .x_in(x_i), .y_in(y_i), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .operand(operand),
        .eff_addr(eff_addr), .pc_out(pc_out)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // memory: closed-form contents plus a few patched bytes
    logic [15:0] ov_a [16];
    logic [7:0]  ov_d [16];
    int          ov_n = 0;

    function automatic logic [7:0] mb(input logic [15:0] a);
        logic [7:0] v;
        v = (a[15:8] * 8'd29) ^ (a[7:0] * 8'd7) ^ 8'h5C;
        for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) v = ov_d[i];
        return v;
    endfunction

    task automatic patch(input logic [15:0] a, input logic [7:0] d);
        ov_a[ov_n] = a;
        ov_d[ov_n] = d;
        ov_n++;
    endtask

    always @(posedge clk) if (mem_rd) mem_rdata <= mb(mem_addr);

    // read log, taken mid-cycle
    logic [15:0] rlog [8];
    int          rlog_n = 0;
    always @(negedge clk) if (mem_rd) begin
        if (rlog_n < 8) rlog[rlog_n] = mem_addr;
        rlog_n++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int m, input int pc, input int x, input int y,
                       input bit inject, output int eff_got);
        int op0, op1, p, lo, hi, e_eff, e_op, e_pcn, n, cnt;
        int rd [4];
        bit got;
        string tag;
        op0 = int'(mb(16'(pc)));
        op1 = int'(mb(16'(pc + 1)));
        e_pcn = (pc + 1) & 16'hFFFF;
        rd[0] = pc; rd[1] = 0; rd[2] = 0; rd[3] = 0;
        case (m)
            0: begin e_eff = pc; n = 1; tag = "R3"; end
            1: begin e_eff = op0; n = 2; tag = "R4"; end
            2: begin e_eff = (op0 + x) & 255; n = 2; tag = "R4"; end
            3, 4, 5: begin
                e_eff = (op1 * 256 + op0 + (m == 4 ? x : (m == 5 ? y : 0))) & 16'hFFFF;
                n = 3; tag = "R5";
                rd[1] = (pc + 1) & 16'hFFFF;
                e_pcn = (pc + 2) & 16'hFFFF;
            end
            default: begin
                p  = (m == 6) ? ((op0 + x) & 255) : op0;
                lo = int'(mb(16'(p)));
                hi = int'(mb(16'((p + 1) & 255)));
                e_eff = (hi * 256 + lo + (m == 7 ? y : 0)) & 16'hFFFF;
                n = 4; tag = (m == 6) ? "R6" : "R7";
                rd[1] = p; rd[2] = (p + 1) & 255;
            end
        endcase
        rd[n-1] = (m == 0) ? pc : e_eff;
        e_op = (m == 0) ? op0 : int'(mb(16'(e_eff)));

        @(negedge clk);
        start = 1'b1; mode_i = 3'(m); pc_i = 16'(pc); x_i = 8'(x); y_i = 8'(y);
        rlog_n = 0; cnt = 0; got = 0;
        while (!got && cnt < 64) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                start = 1'b1; mode_i = 3'd0; pc_i = 16'hAAAA; x_i = 8'h11; y_i = 8'h33;
            end else start = 1'b0;
            if (done) got = 1;
        end
        start = 1'b0;
        chk(got, "R8", "done seen", int'(got), 1);
        chk(cnt == 2 * n + 1, "R2", "cycles to done", cnt, 2 * n + 1);
        chk(rlog_n == n, "R2", "read count", rlog_n, n);
        for (int i = 0; i < n; i++)
            chk(rlog[i] == 16'(rd[i]), "R2", "read order", int'(rlog[i]), rd[i]);
        chk(eff_addr == 16'(e_eff), tag, "effective address", int'(eff_addr), e_eff);
        chk(operand == 8'(e_op), "R8", "operand", int'(operand), e_op);
        chk(pc_out == 16'(e_pcn), "R10", "pc_out", int'(pc_out), e_pcn);
        eff_got = int'(eff_addr);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", int'(done), 0);
        if (inject) chk(!busy && rlog_n == n, "R9", "start while busy ignored",
                        int'(busy) * 16 + rlog_n, n);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int e;
        int pcs [3];
        int vals [4];
        pcs[0] = 16'h0200; pcs[1] = 16'h12FF; pcs[2] = 16'hFFFF;
        vals[0] = 8'h00; vals[1] = 8'h22; vals[2] = 8'h80; vals[3] = 8'hFF;

        patch(16'h0300, 8'hF1);
        patch(16'h0400, 8'hF1); patch(16'h0401, 8'h36);
        patch(16'h0500, 8'h41); patch(16'h0063, 8'h34); patch(16'h0064, 8'h12);
        patch(16'h0600, 8'h41); patch(16'h0041, 8'h34); patch(16'h0042, 8'h12);
        patch(16'h0700, 8'hFF); patch(16'h00FF, 8'h80); patch(16'h0000, 8'h20);
        patch(16'h0800, 8'hF9); patch(16'h0801, 8'hFF);
        patch(16'h0900, 8'hF0);
        patch(16'h0A00, 8'hF0);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_rd, "R1", "reset outputs",
            int'({busy, done, mem_rd}), 0);
        rst = 1'b0;

        // worked examples and wrap corners
        run(2, 16'h0300, 5, 0, 0, e);
        chk(e == 16'h00F6, "R4", "page-zero+X example", e, 16'h00F6);
        run(2, 16'h0900, 8'h20, 0, 0, e);
        chk(e == 16'h0010, "R4", "page-zero+X wrap", e, 16'h0010);
        run(4, 16'h0400, 8, 0, 0, e);
        chk(e == 16'h36F9, "R5", "absolute+X example", e, 16'h36F9);
        run(4, 16'h0800, 8'h10, 0, 0, e);
        chk(e == 16'h0009, "R5", "absolute+X top wrap", e, 16'h0009);
        run(6, 16'h0500, 8'h22, 0, 0, e);
        chk(e == 16'h1234, "R6", "pre-indexed example", e, 16'h1234);
        run(6, 16'h0A00, 8'h0F, 0, 0, e);
        chk(e == 16'h2080, "R6", "pre-indexed pointer wrap", e, 16'h2080);
        run(7, 16'h0600, 0, 8'h22, 0, e);
        chk(e == 16'h1256, "R7", "post-indexed example", e, 16'h1256);
        run(7, 16'h0700, 0, 8'h05, 0, e);
        chk(e == 16'h2085, "R7", "post-indexed pointer wrap", e, 16'h2085);
        run(0, 16'h0300, 0, 0, 0, e);
        chk(e == 16'h0300 && operand == 8'hF1, "R3", "immediate value",
            int'(operand), 8'hF1);

        // sweep all modes over start addresses and index values
        for (int m = 0; m < 8; m++)
            for (int pi = 0; pi < 3; pi++)
                for (int vi = 0; vi < 4; vi++)
                    run(m, pcs[pi], vals[vi], vals[vi] ^ 8'h5A, 0, e);

        // R9 start pulses while busy
        for (int m = 1; m < 8; m++) run(m, 16'h0500, 8'h22, 8'h22, 1, e);

        // R1 reset during a sequence
        @(negedge clk);
        start = 1'b1; mode_i = 3'd7; pc_i = 16'h0600; y_i = 8'h22;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd, "R1", "reset mid-sequence",
            int'({busy, done, mem_rd}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd, "R1", "idle after reset", int'({busy, mem_rd}), 0);
        run(3, 16'h0400, 0, 0, 0, e);
        chk(e == 16'h36F1, "R5", "absolute after reset", e, 16'h36F1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule